// File: doc/BRIEF.md
# Burst-of-Four Dual-Path Memory Sequencer

This block drives a small synchronous memory that has one path for reads and a separate path for writes. A read burst and a write burst can be in flight at the same moment. Both selects are active-low and are sampled on the rising edge of `clk_i`. When a select is accepted, the address beside it is latched as the burst start. The port then moves four consecutive words, two in each clock cycle. One word travels on a rise lane and one on a fall lane, which together stand for the two edges of a double-rate transfer.

Each path has its own sequencer. The sequencer counts double-rate transfers from zero and ends the burst when the count reaches two. It steps the low two address bits linearly and wraps them, so the upper address bits never change during a burst. Read data appears in registers one cycle after each transfer cycle and is flagged by `rd_valid_o`. Write data is taken from the input lanes in the two cycles after the write command. A request that arrives in the last transfer cycle of a burst starts the next burst with no gap. A request that arrives earlier in a burst is dropped.

Top module: `burst4_sram_core`

## Requirements
- R1: While `rst_ni` is low, both sequencers are idle, their transfer counts are zero and `rd_valid_o` is 0. After release, no burst runs until a select is sampled low.
- R2: An idle read path that samples `rd_n_i` low at rising edge E0 drives `rd_valid_o` high in the two cycles following edge E0+1. If no new read is accepted, `rd_valid_o` returns low after those two cycles.
- R3: A write sampled with `wr_n_i` low at edge E0 stores burst words 0 and 1, taken from the rise and fall lanes in the cycle after E0. It stores words 2 and 3 from those lanes in the next cycle.
- R4: For a start address A, burst word i (i = 0..3) goes to address {A[AW-1:2], (A[1:0]+i) mod 4}. The upper address bits stay fixed and the low two bits wrap.
- R5: Read data arrives in linear word order. The rise lane carries words 0 and 2 and the fall lane carries words 1 and 3. Word 0 and word 1 come in the first valid cycle.
- R6: A select sampled low during the first transfer cycle of a burst on the same path is ignored. It starts no burst and moves no data.
- R7: A select sampled low during the last transfer cycle of a burst starts a new burst on that path at the next edge, with no idle cycle between the two bursts.
- R8: The read and write paths run independently. A read and a write commanded in the same cycle both complete with their normal timing.
- R9: When a burst ends and its select is high, the path returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock, rising edge samples commands |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_n_i | input | 1 | Read select, active low |
| rd_addr_i | input | AW | Read burst start address |
| wr_n_i | input | 1 | Write select, active low |
| wr_addr_i | input | AW | Write burst start address |
| wr_data_rise_i | input | DW | Write word for the rising-edge lane (words 0, 2) |
| wr_data_fall_i | input | DW | Write word for the falling-edge lane (words 1, 3) |
| rd_data_rise_o | output | DW | Read word on the rising-edge lane (words 0, 2) |
| rd_data_fall_o | output | DW | Read word on the falling-edge lane (words 1, 3) |
| rd_valid_o | output | 1 | Read lanes hold burst data |

## Verification
A table of start addresses covers every value of the low two bits, including the case where the burst wraps from offset 3 to 0. Each entry does a write and then a read. A wrong wrap, lane swap or word order therefore shows up as a mismatch against a reference array. Directed sequences then pit a second select against the burst already running:
- A select in the first transfer cycle must be dropped on both paths.
- A select in the last transfer cycle must chain with no gap.
- A read and a write commanded in the same cycle must not disturb each other.

A reset in the middle of a burst must cancel the valid flag.

// File: rtl/burst4_pkg.sv
package burst4_pkg;
  localparam int unsigned BURST_LEN = 4;
  localparam int unsigned RATE      = 2;
  localparam int unsigned BEATS     = BURST_LEN / RATE;
  localparam int unsigned CNT_W     = $clog2(BEATS + 1);
  localparam int unsigned OFF_W     = $clog2(BURST_LEN);

  typedef enum logic {
    ST_NOP  = 1'b0,
    ST_XFER = 1'b1
  } port_state_e;
endpackage

// File: rtl/burst4_port_fsm.sv
module burst4_port_fsm
  import burst4_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic [AW-1:0]          addr_i,
  output logic                   active_o,
  output logic                   last_o,
  output logic [RATE-1:0][AW-1:0] addr_o
);
  port_state_e      st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic [AW-1:0]    base_q, base_d;
  logic             done, accept;

  assign cnt_inc = cnt_q + CNT_W'(1);
  assign done    = (st_q == ST_XFER) && (cnt_inc == CNT_W'(BEATS));
  // new command only when idle or finishing
  assign accept  = req_i && ((st_q == ST_NOP) || done);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    base_d = base_q;
    if (accept) begin
      st_d   = ST_XFER;
      cnt_d  = '0;
      base_d = addr_i;
    end else if (done) begin
      st_d  = ST_NOP;
      cnt_d = '0;
    end else if (st_q == ST_XFER) begin
      cnt_d = cnt_inc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_NOP;
      cnt_q  <= '0;
      base_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      base_q <= base_d;
    end
  end

  assign active_o = (st_q == ST_XFER);
  assign last_o   = (cnt_q == CNT_W'(BEATS - 1));

  // linear offset, wraps inside the low OFF_W bits
  for (genvar l = 0; l < RATE; l++) begin : g_lane
    logic [OFF_W-1:0] off;
    assign off       = base_q[OFF_W-1:0] + OFF_W'(32'(cnt_q) * RATE + 32'(l));
    assign addr_o[l] = {base_q[AW-1:OFF_W], off};
  end
endmodule

// File: rtl/burst4_mem.sv
module burst4_mem
  import burst4_pkg::*;
#(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 36
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [RATE-1:0][AW-1:0] waddr_i,
  input  logic [RATE-1:0][DW-1:0] wdata_i,
  input  logic                    re_i,
  input  logic [RATE-1:0][AW-1:0] raddr_i,
  output logic [RATE-1:0][DW-1:0] rdata_o,
  output logic                    rvalid_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      for (int l = 0; l < RATE; l++) mem_q[waddr_i[l]] <= wdata_i[l];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= re_i;
      if (re_i) begin
        for (int l = 0; l < RATE; l++) rdata_o[l] <= mem_q[raddr_i[l]];
      end
    end
  end
endmodule

// File: rtl/burst4_sram_core.sv
module burst4_sram_core
  import burst4_pkg::*;
#(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 36
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_n_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic          wr_n_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_rise_i,
  input  logic [DW-1:0] wr_data_fall_i,
  output logic [DW-1:0] rd_data_rise_o,
  output logic [DW-1:0] rd_data_fall_o,
  output logic          rd_valid_o
);
  logic                    rd_act, rd_last, wr_act, wr_last;
  logic [RATE-1:0][AW-1:0] rd_addr, wr_addr;
  logic [RATE-1:0][DW-1:0] wdata, rdata;

  burst4_port_fsm #(.AW(AW)) i_rd_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (!rd_n_i),
    .addr_i  (rd_addr_i),
    .active_o(rd_act),
    .last_o  (rd_last),
    .addr_o  (rd_addr)
  );

  burst4_port_fsm #(.AW(AW)) i_wr_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (!wr_n_i),
    .addr_i  (wr_addr_i),
    .active_o(wr_act),
    .last_o  (wr_last),
    .addr_o  (wr_addr)
  );

  assign wdata[0] = wr_data_rise_i;
  assign wdata[1] = wr_data_fall_i;

  burst4_mem #(.AW(AW), .DW(DW)) i_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_act),
    .waddr_i (wr_addr),
    .wdata_i (wdata),
    .re_i    (rd_act),
    .raddr_i (rd_addr),
    .rdata_o (rdata),
    .rvalid_o(rd_valid_o)
  );

  assign rd_data_rise_o = rdata[0];
  assign rd_data_fall_o = rdata[1];
endmodule

// File: rtl/burst4_sram_core_chk.sv
module burst4_sram_core_chk
  import burst4_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rd_n_i,
  input logic          wr_n_i,
  input logic          rd_act,
  input logic          rd_last,
  input logic          wr_act,
  input logic          wr_last,
  input logic          rd_valid_o,
  input logic [AW-1:0] rd_a0,
  input logic [AW-1:0] wr_a0
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_idle_R1: assert (!rd_act && !wr_act && !rd_valid_o);
    end
  end

  assert_rd_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_act && !rd_n_i) |=> (rd_act && !rd_last));
  assert_rd_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_act |=> rd_valid_o);
  assert_rd_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_act |=> !rd_valid_o);
  assert_wr_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_act && !wr_n_i) |=> (wr_act && !wr_last));

  assert_rd_upper_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_act && rd_last) |-> (rd_a0[AW-1:OFF_W] == $past(rd_a0[AW-1:OFF_W])));
  assert_wr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_act && wr_last) |->
      (wr_a0[OFF_W-1:0] == OFF_W'($past(wr_a0[OFF_W-1:0]) + OFF_W'(RATE))));

  assert_rd_no_cut_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_act && !rd_last) |=> (rd_act && rd_last));
  assert_wr_no_cut_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_act && !wr_last) |=> (wr_act && wr_last));

  assert_rd_chain_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_act && rd_last && !rd_n_i) |=> (rd_act && !rd_last));
  assert_wr_chain_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_act && wr_last && !wr_n_i) |=> (wr_act && !wr_last));

  assert_rd_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_act && rd_last && rd_n_i) |=> !rd_act);
  assert_wr_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_act && wr_last && wr_n_i) |=> !wr_act);
endmodule

bind burst4_sram_core burst4_sram_core_chk #(.AW(AW)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_n_i    (rd_n_i),
  .wr_n_i    (wr_n_i),
  .rd_act    (rd_act),
  .rd_last   (rd_last),
  .wr_act    (wr_act),
  .wr_last   (wr_last),
  .rd_valid_o(rd_valid_o),
  .rd_a0     (rd_addr[0]),
  .wr_a0     (wr_addr[0])
);

// File: tb/test_burst4_sram_core.sv
`timescale 1ns/1ps
module test_burst4_sram_core;
  localparam int unsigned AW = 6;
  localparam int unsigned DW = 36;
  localparam int unsigned NV = 8;

  // {start address, data seed}
  localparam logic [13:0] VEC [NV] = '{
    {6'd0,  8'h11}, {6'd5,  8'h22}, {6'd10, 8'h33}, {6'd15, 8'h44},
    {6'd20, 8'h55}, {6'd33, 8'h66}, {6'd46, 8'h77}, {6'd63, 8'h88}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_n = 1'b1, wr_n = 1'b1;
  logic [AW-1:0] rd_addr = '0, wr_addr = '0;
  logic [DW-1:0] d_rise = '0, d_fall = '0;
  logic [DW-1:0] q_rise, q_fall;
  logic          q_valid;

  logic [DW-1:0] ref_mem [64];
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  burst4_sram_core #(.AW(AW), .DW(DW)) i_burst4_sram_core (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .rd_n_i        (rd_n),
    .rd_addr_i     (rd_addr),
    .wr_n_i        (wr_n),
    .wr_addr_i     (wr_addr),
    .wr_data_rise_i(d_rise),
    .wr_data_fall_i(d_fall),
    .rd_data_rise_o(q_rise),
    .rd_data_fall_o(q_fall),
    .rd_valid_o    (q_valid)
  );

  function automatic logic [DW-1:0] mk(input logic [7:0] s, input int i);
    return {s[3:0], s, s, s, s} ^ DW'(36'h111111111 * (i + 1));
  endfunction

  function automatic logic [AW-1:0] ba(input logic [AW-1:0] a, input int i);
    return {a[AW-1:2], 2'(32'(a[1:0]) + i)};
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_burst(input logic [AW-1:0] a, input logic [7:0] s);
    @(negedge clk); wr_n = 1'b0; wr_addr = a;
    @(negedge clk); wr_n = 1'b1; d_rise = mk(s, 0); d_fall = mk(s, 1);
    @(negedge clk); d_rise = mk(s, 2); d_fall = mk(s, 3);
    for (int i = 0; i < 4; i++) ref_mem[ba(a, i)] = mk(s, i);
  endtask

  // checks one valid cycle carrying words w and w+1 of burst a
  task automatic chk_pair(input string req, input logic [AW-1:0] a, input int w);
    chk({req, " valid"}, DW'(q_valid), DW'(1));
    chk({req, " rise"}, q_rise, ref_mem[ba(a, w)]);
    chk({req, " fall"}, q_fall, ref_mem[ba(a, w + 1)]);
  endtask

  task automatic rd_burst(input string req, input logic [AW-1:0] a);
    @(negedge clk); rd_n = 1'b0; rd_addr = a;
    @(negedge clk); rd_n = 1'b1;
    @(negedge clk); chk_pair(req, a, 0);
    @(negedge clk); chk_pair(req, a, 2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", DW'(q_valid), DW'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after release", DW'(q_valid), DW'(0));

    // table: write then read back, all low-bit offsets (R3 R4 R5)
    for (int v = 0; v < NV; v++) begin
      wr_burst(VEC[v][13:8], VEC[v][7:0]);
      rd_burst("R3 R4 R5 table", VEC[v][13:8]);
      @(negedge clk);
      chk("R9 idle after read", DW'(q_valid), DW'(0));
    end

    // R2: valid appears exactly two cycles after command edge
    @(negedge clk); rd_n = 1'b0; rd_addr = 6'd5;
    @(negedge clk); rd_n = 1'b1;
    chk("R2 no valid at first transfer", DW'(q_valid), DW'(0));
    @(negedge clk); chk_pair("R2", 6'd5, 0);
    @(negedge clk); chk_pair("R2", 6'd5, 2);
    @(negedge clk); chk("R2 valid drop", DW'(q_valid), DW'(0));

    // R6: read select in first transfer cycle ignored
    @(negedge clk); rd_n = 1'b0; rd_addr = 6'd10;
    @(negedge clk); rd_n = 1'b0; rd_addr = 6'd20;
    @(negedge clk); rd_n = 1'b1; chk_pair("R6 rd", 6'd10, 0);
    @(negedge clk); chk_pair("R6 rd", 6'd10, 2);
    @(negedge clk); chk("R6 rd no extra burst", DW'(q_valid), DW'(0));

    // R6: write select in first transfer cycle ignored, target keeps old data
    @(negedge clk); wr_n = 1'b0; wr_addr = 6'd0;
    @(negedge clk); wr_n = 1'b0; wr_addr = 6'd33; d_rise = mk(8'hA1, 0); d_fall = mk(8'hA1, 1);
    @(negedge clk); wr_n = 1'b1; d_rise = mk(8'hA1, 2); d_fall = mk(8'hA1, 3);
    for (int i = 0; i < 4; i++) ref_mem[ba(6'd0, i)] = mk(8'hA1, i);
    rd_burst("R6 wr untouched", 6'd33);
    rd_burst("R6 wr first burst", 6'd0);

    // R7: back-to-back reads with no gap
    @(negedge clk); rd_n = 1'b0; rd_addr = 6'd15;
    @(negedge clk); rd_n = 1'b1;
    @(negedge clk); rd_n = 1'b0; rd_addr = 6'd46; chk_pair("R7 first", 6'd15, 0);
    @(negedge clk); rd_n = 1'b1; chk_pair("R7 first", 6'd15, 2);
    @(negedge clk); chk_pair("R7 second", 6'd46, 0);
    @(negedge clk); chk_pair("R7 second", 6'd46, 2);
    @(negedge clk); chk("R9 idle after chain", DW'(q_valid), DW'(0));

    // R7: back-to-back writes
    @(negedge clk); wr_n = 1'b0; wr_addr = 6'd21;
    @(negedge clk); wr_n = 1'b1; d_rise = mk(8'hB2, 0); d_fall = mk(8'hB2, 1);
    @(negedge clk); wr_n = 1'b0; wr_addr = 6'd42; d_rise = mk(8'hB2, 2); d_fall = mk(8'hB2, 3);
    @(negedge clk); wr_n = 1'b1; d_rise = mk(8'hC3, 0); d_fall = mk(8'hC3, 1);
    @(negedge clk); d_rise = mk(8'hC3, 2); d_fall = mk(8'hC3, 3);
    for (int i = 0; i < 4; i++) begin
      ref_mem[ba(6'd21, i)] = mk(8'hB2, i);
      ref_mem[ba(6'd42, i)] = mk(8'hC3, i);
    end
    rd_burst("R7 wr first", 6'd21);
    rd_burst("R7 wr second", 6'd42);

    // R8: read and write commanded together
    @(negedge clk); rd_n = 1'b0; rd_addr = 6'd63; wr_n = 1'b0; wr_addr = 6'd50;
    @(negedge clk); rd_n = 1'b1; wr_n = 1'b1; d_rise = mk(8'hD4, 0); d_fall = mk(8'hD4, 1);
    @(negedge clk); d_rise = mk(8'hD4, 2); d_fall = mk(8'hD4, 3); chk_pair("R8 read", 6'd63, 0);
    @(negedge clk); chk_pair("R8 read", 6'd63, 2);
    for (int i = 0; i < 4; i++) ref_mem[ba(6'd50, i)] = mk(8'hD4, i);
    rd_burst("R8 write", 6'd50);

    // R1: reset in mid-burst cancels it
    @(negedge clk); rd_n = 1'b0; rd_addr = 6'd20;
    @(negedge clk); rd_n = 1'b1; rst_n = 1'b0;
    @(negedge clk); chk("R1 mid-burst reset", DW'(q_valid), DW'(0));
    rst_n = 1'b1;
    @(negedge clk); chk("R1 no resume", DW'(q_valid), DW'(0));
    @(negedge clk); chk("R1 stays idle", DW'(q_valid), DW'(0));
    rd_burst("R1 after reset", 6'd20);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule